// File: doc/BRIEF.md
# Serial Flash Continuous Read Sequencer

This block is the host side of a streaming read from an SPI serial flash. A single start pulse sends one read command and then streams any number of bytes back. The command carries one of three read opcodes, a 24-bit address field and, for the fast variant only, one dummy byte. The received bytes come out one at a time with a valid strobe, and a done pulse marks the end of the transfer. The block generates the serial clock from the system clock through a parameterized divider and uses SPI mode 0: the clock idles low, the block changes MOSI on falling edges and samples MISO on rising edges.

The flash may be organised in either of two ways. In the first, pages are 528 bytes long and each location is named by a page number plus a byte offset. In the second, the address is one flat binary byte address. The page-organisation input selects how the address field is built. A request may run past the end of a page or past the end of the whole array, because the flash carries on reading without a pause. The sequencer therefore sends the command once and holds chip select low for the whole transfer.

Top module: `flash_read_seq`

## Requirements
- R1: The opcode follows `rdMode`: 2'b00 sends 8'h03, 2'b01 sends 8'h0B, 2'b10 sends 8'h01, and the reserved code 2'b11 sends 8'h03.
- R2: In fast mode (2'b01) one all-zero byte follows the address, so the header is 40 bits. In the other modes the header is 32 bits. The transfer has exactly header + 8 × `byteCount` rising SCK edges.
- R3: When `page528` is 1, the address field is {2'b00, `pageNum`[11:0], `byteOfs`[9:0]}, with the page number in bits 21:10 and the offset in bits 9:0.
- R4: When `page528` is 0, the address field is {3'b000, `flatAddr`[20:0]}.
- R5: SCK is low whenever `csN` is high. The SCK period is 2·CLK_DIV system clocks. Each byte leaves on MOSI MSB first, and MOSI changes only on falling SCK edges while `csN` is low.
- R6: `csN` goes low exactly once per transfer and stays low until the last requested bit. Page and array boundaries never cause a second command.
- R7: `rxValid` pulses for one cycle per received byte, exactly `byteCount` times. `rxData` holds the byte, assembled MSB first from MISO.
- R8: When a transfer ends, `done` is high for exactly one cycle. In that cycle `csN` is high and `busy` is low, and `busy` never falls without `done`.
- R9: `busy` goes high in the cycle after an accepted start. While `busy` is high, `start` is ignored: the opcode, the address and the byte count of the running transfer stay unchanged.
- R10: A start with `byteCount` equal to 0 is ignored. `busy` stays low and `csN` stays high.
- R11: During reset and right after it, `csN` is high, `sck` is low, and `busy`, `done` and `rxValid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin a read |
| rdMode | input | 2 | Read variant: 0 normal, 1 fast, 2 low-power, 3 reserved (normal) |
| page528 | input | 1 | 1: page/offset addressing, 0: flat addressing |
| pageNum | input | PAGE_W | Page number in page/offset addressing |
| byteOfs | input | OFS_W | Byte offset within the page |
| flatAddr | input | FLAT_W | Flat byte address |
| byteCount | input | CNT_W | Number of bytes to read |
| sck | output | 1 | Serial clock |
| csN | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to the flash |
| miso | input | 1 | Serial data from the flash |
| rxData | output | 8 | Last received byte |
| rxValid | output | 1 | One-cycle strobe for `rxData` |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |

## Verification
A behavioural flash model decodes the header it receives and answers with a position-dependent byte pattern. The main function is run with every opcode code, including the reserved one, under both addressing schemes. The patterns cover a start inside a page, a run across a 528-byte page edge, and wraps past the end of the array in both layouts. Comparing the opcode and the address the model decoded separates R1 from R3/R4. The rising-edge count and the correctness of the first data byte show whether the dummy byte was sent only in fast mode. Byte streams across the edges show whether the block reissued the command or broke chip select.

// File: rtl/frs_pkg.sv
package frs_pkg;
  typedef enum logic [1:0] {
    RD_NORMAL = 2'b00,
    RD_FAST   = 2'b01,
    RD_LOWPWR = 2'b10,
    RD_RSVD   = 2'b11
  } rd_mode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // latch header, assert chip select
    logic rise;     // SCK rising edge
    logic fall;     // SCK falling edge, advance MOSI
    logic capture;  // sample MISO into the receive shifter
    logic byteEnd;  // eighth data bit of a byte captured
    logic finish;   // release chip select
  } frs_strobe_t;

  localparam int HDR_BITS_SLOW = 32;
  localparam int HDR_BITS_FAST = 40;

  function automatic logic [7:0] opcodeFor(rd_mode_e m);
    case (m)
      RD_FAST:   return 8'h0B;
      RD_LOWPWR: return 8'h01;
      default:   return 8'h03;
    endcase
  endfunction
endpackage

// File: rtl/frs_ctrl.sv
module frs_ctrl
  import frs_pkg::*;
#(
  parameter int CLK_DIV = 2,
  parameter int CNT_W   = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  rd_mode_e         mode,
  input  logic [CNT_W-1:0] byteCount,
  output frs_strobe_t      stb,
  output logic             busy,
  output logic             done
);
  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);

  typedef enum logic {ST_IDLE, ST_RUN} st_e;
  st_e              state;
  logic [DIV_W-1:0] divCnt;
  logic             hiPhase;
  logic [5:0]       hdrLeft;
  logic [2:0]       bitPos;
  logic [CNT_W-1:0] bytesLeft;
  logic             allIn;
  logic             tick;

  assign tick = (divCnt == DIV_LAST);
  assign busy = (state == ST_RUN);

  always_comb begin
    stb = '0;
    if (state == ST_IDLE) begin
      stb.load = start && (byteCount != '0);
    end else if (tick) begin
      if (!hiPhase) begin
        stb.rise    = 1'b1;
        stb.capture = (hdrLeft == 6'd0);
        stb.byteEnd = (hdrLeft == 6'd0) && (bitPos == 3'd7);
      end else begin
        stb.fall   = 1'b1;
        stb.finish = allIn;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      divCnt    <= '0;
      hiPhase   <= 1'b0;
      hdrLeft   <= '0;
      bitPos    <= '0;
      bytesLeft <= '0;
      allIn     <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= stb.finish;
      if (state == ST_IDLE) begin
        if (stb.load) begin
          state     <= ST_RUN;
          divCnt    <= '0;
          hiPhase   <= 1'b0;
          hdrLeft   <= (mode == RD_FAST) ? 6'(HDR_BITS_FAST) : 6'(HDR_BITS_SLOW);
          bitPos    <= '0;
          bytesLeft <= byteCount;
          allIn     <= 1'b0;
        end
      end else begin
        divCnt <= tick ? '0 : divCnt + 1'b1;
        if (stb.rise) begin
          hiPhase <= 1'b1;
          if (hdrLeft != 6'd0) hdrLeft <= hdrLeft - 1'b1;
        end
        if (stb.capture) bitPos <= bitPos + 1'b1;
        if (stb.byteEnd) begin
          bytesLeft <= bytesLeft - 1'b1;
          if (bytesLeft == CNT_W'(1)) allIn <= 1'b1;
        end
        if (stb.fall) hiPhase <= 1'b0;
        if (stb.finish) state <= ST_IDLE;
      end
    end
  end
endmodule

// File: rtl/frs_datapath.sv
module frs_datapath
  import frs_pkg::*;
#(
  parameter int PAGE_W = 12,
  parameter int OFS_W  = 10,
  parameter int FLAT_W = 21
) (
  input  logic              clk,
  input  logic              rstN,
  input  frs_strobe_t       stb,
  input  rd_mode_e          mode,
  input  logic              page528,
  input  logic [PAGE_W-1:0] pageNum,
  input  logic [OFS_W-1:0]  byteOfs,
  input  logic [FLAT_W-1:0] flatAddr,
  input  logic              miso,
  output logic              sck,
  output logic              csN,
  output logic              mosi,
  output logic [7:0]        rxData,
  output logic              rxValid
);
  localparam int ADDR_W = 24;
  localparam int TX_W   = 8 + ADDR_W + 8;

  logic [ADDR_W-1:0] addrField;
  logic [TX_W-1:0]   txShift;
  logic [7:0]        rxShift;

  // page/offset packing or flat address, zero-extended to the field
  assign addrField = page528 ? ADDR_W'({pageNum, byteOfs}) : ADDR_W'(flatAddr);
  assign mosi      = txShift[TX_W-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sck     <= 1'b0;
      csN     <= 1'b1;
      txShift <= '0;
      rxShift <= '0;
      rxData  <= '0;
      rxValid <= 1'b0;
    end else begin
      rxValid <= stb.byteEnd;
      if (stb.load) begin
        csN     <= 1'b0;
        txShift <= {opcodeFor(mode), addrField, 8'h00};
      end
      if (stb.rise) sck <= 1'b1;
      if (stb.fall) begin
        sck     <= 1'b0;
        txShift <= {txShift[TX_W-2:0], 1'b0};
      end
      if (stb.capture) rxShift <= {rxShift[6:0], miso};
      if (stb.byteEnd) rxData <= {rxShift[6:0], miso};
      if (stb.finish) csN <= 1'b1;
    end
  end
endmodule

// File: rtl/flash_read_seq.sv
module flash_read_seq
  import frs_pkg::*;
#(
  parameter int CLK_DIV = 2,
  parameter int CNT_W   = 16,
  parameter int PAGE_W  = 12,
  parameter int OFS_W   = 10,
  parameter int FLAT_W  = 21
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [1:0]        rdMode,
  input  logic              page528,
  input  logic [PAGE_W-1:0] pageNum,
  input  logic [OFS_W-1:0]  byteOfs,
  input  logic [FLAT_W-1:0] flatAddr,
  input  logic [CNT_W-1:0]  byteCount,
  output logic              sck,
  output logic              csN,
  output logic              mosi,
  input  logic              miso,
  output logic [7:0]        rxData,
  output logic              rxValid,
  output logic              busy,
  output logic              done
);
  frs_strobe_t stb;
  rd_mode_e    mode;

  assign mode = rd_mode_e'(rdMode);

  frs_ctrl #(.CLK_DIV(CLK_DIV), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode),
    .byteCount(byteCount), .stb(stb), .busy(busy), .done(done)
  );

  frs_datapath #(.PAGE_W(PAGE_W), .OFS_W(OFS_W), .FLAT_W(FLAT_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .mode(mode), .page528(page528),
    .pageNum(pageNum), .byteOfs(byteOfs), .flatAddr(flatAddr), .miso(miso),
    .sck(sck), .csN(csN), .mosi(mosi), .rxData(rxData), .rxValid(rxValid)
  );
endmodule

// File: rtl/frs_checker.sv
module frs_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic [CNT_W-1:0] byteCount,
  input logic             sck,
  input logic             csN,
  input logic             mosi,
  input logic             rxValid,
  input logic             busy,
  input logic             done
);
  a_r5_sck_idle_low: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sck);
  a_r5_mosi_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && $past(!csN) && !$stable(mosi)) |-> $fell(sck));
  a_r6_cs_follows_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !csN);
  a_r7_valid_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (csN && !busy));
  a_r8_busy_fall_done: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);
  a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> (busy || done));
  a_r10_zero_count: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start && byteCount == '0) |=> !busy);
  a_r11_reset_idle: assert property (@(posedge clk)
    !rstN |=> (csN && !sck && !busy && !done && !rxValid));
endmodule

bind flash_read_seq frs_checker #(.CNT_W(CNT_W)) u_frs_checker (
  .clk(clk), .rstN(rstN), .start(start), .byteCount(byteCount),
  .sck(sck), .csN(csN), .mosi(mosi), .rxValid(rxValid),
  .busy(busy), .done(done)
);

// File: tb/flash_read_seq_bench.sv
`timescale 1ns/1ps
module flash_read_seq_bench;
  localparam int DIV = 3;
  localparam int CW  = 16;

  typedef struct packed {
    logic [1:0]  md;
    logic        pm;
    logic [11:0] pg;
    logic [9:0]  of;
    logic [20:0] fl;
    logic [7:0]  n;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VEC [0:NV-1] = '{
    '{2'd0, 1'b1, 12'd3,    10'd17,  21'd0,        8'd4},
    '{2'd1, 1'b1, 12'd100,  10'd0,   21'd0,        8'd3},
    '{2'd2, 1'b1, 12'd5,    10'd524, 21'd0,        8'd8},
    '{2'd0, 1'b0, 12'd0,    10'd0,   21'h1234A,    8'd5},
    '{2'd1, 1'b0, 12'd0,    10'd0,   21'h1FFFFC,   8'd8},
    '{2'd3, 1'b1, 12'd4095, 10'd520, 21'd0,        8'd12},
    '{2'd1, 1'b1, 12'd2048, 10'd527, 21'd0,        8'd2}
  };

  logic clk = 0, rstN = 0, start = 0, page528 = 0, miso = 0;
  logic [1:0]  rdMode = 0;
  logic [11:0] pageNum = 0;
  logic [9:0]  byteOfs = 0;
  logic [20:0] flatAddr = 0;
  logic [CW-1:0] byteCount = 0;
  logic sck, csN, mosi, rxValid, busy, done;
  logic [7:0] rxData;

  always #2.5 clk = ~clk;

  flash_read_seq #(.CLK_DIV(DIV), .CNT_W(CW)) u_flash_read_seq (
    .clk(clk), .rstN(rstN), .start(start), .rdMode(rdMode), .page528(page528),
    .pageNum(pageNum), .byteOfs(byteOfs), .flatAddr(flatAddr),
    .byteCount(byteCount), .sck(sck), .csN(csN), .mosi(mosi), .miso(miso),
    .rxData(rxData), .rxValid(rxValid), .busy(busy), .done(done)
  );

  int errors = 0, checks = 0, cyc = 0;

  function automatic int arrSize(logic pm);
    return pm ? 4096 * 528 : 2097152;
  endfunction
  function automatic logic [7:0] byteAt(int lin);
    return 8'((lin * 13) ^ (lin >>> 10));
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- flash model ----------------
  int riseCnt = 0, outBits = 0, csFalls = 0, sckRises = 0, mStart = 0, hl = 0;
  int lastRise = -1, periodErr = 0;
  logic [39:0] hdr = '0;
  logic [7:0]  mOp = '0;
  logic [23:0] mAddr = '0;
  logic        tbPm = 0;

  always @(negedge csN) begin
    riseCnt = 0; outBits = 0; csFalls++; lastRise = -1;
  end
  always @(posedge sck) if (!csN) begin
    hdr = {hdr[38:0], mosi};
    riseCnt++; sckRises++;
    if (lastRise >= 0 && (cyc - lastRise) != 2 * DIV) periodErr++;
    lastRise = cyc;
    if (riseCnt == 8) mOp = hdr[7:0];
    if (riseCnt == 32) begin
      mAddr = hdr[23:0];
      mStart = tbPm ? int'(mAddr[21:10]) * 528 + int'(mAddr[9:0]) : int'(mAddr[20:0]);
    end
  end
  always @(negedge sck) if (!csN) begin
    hl = (mOp == 8'h0B) ? 40 : 32;
    if (riseCnt >= hl) begin
      miso = byteAt((mStart + outBits / 8) % arrSize(tbPm))[7 - (outBits % 8)];
      outBits++;
    end
  end

  // ---------------- output monitor ----------------
  logic [7:0] rxBuf [0:63];
  int rxN = 0, doneCnt = 0;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    if (rxValid) begin
      if (rxN < 64) rxBuf[rxN] = rxData;
      rxN++;
    end
    if (done) doneCnt++;
  end

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic clearStats();
    csFalls = 0; sckRises = 0; rxN = 0; doneCnt = 0; periodErr = 0;
  endtask

  task automatic launch(vec_t v);
    @(negedge clk);
    rdMode = v.md; page528 = v.pm; pageNum = v.pg; byteOfs = v.of;
    flatAddr = v.fl; byteCount = CW'(v.n); tbPm = v.pm; start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic waitDone();
    for (int i = 0; i < 20000 && doneCnt == 0; i++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    // R11: reset state
    repeat (3) @(negedge clk);
    check(csN === 1'b1 && sck === 1'b0, "R11", "cs/sck in reset", {csN, sck}, 2'b10);
    check(!busy && !done && !rxValid, "R11", "busy/done/valid in reset",
          {busy, done, rxValid}, 0);
    rstN = 1;
    @(negedge clk);
    check(csN === 1'b1 && !busy, "R11", "idle after reset", {csN, busy}, 2'b10);

    // table-driven transfers
    for (int k = 0; k < NV; k++) begin
      vec_t v = VEC[k];
      logic [7:0]  eOp  = (v.md == 2'd1) ? 8'h0B : (v.md == 2'd2) ? 8'h01 : 8'h03;
      logic [23:0] eAdr = v.pm ? {2'b00, v.pg, v.of} : {3'b000, v.fl};
      int eHdr = (v.md == 2'd1) ? 40 : 32;
      int eLin = v.pm ? int'(v.pg) * 528 + int'(v.of) : int'(v.fl);
      int bad = 0;
      clearStats();
      launch(v);
      check(busy === 1'b1, "R9", "busy after start", busy, 1);
      waitDone();
      check(mOp == eOp, "R1", "opcode", mOp, eOp);
      check(mAddr == eAdr, v.pm ? "R3" : "R4", "address field", mAddr, eAdr);
      check(sckRises == eHdr + 8 * int'(v.n), "R2", "sck rises", sckRises, eHdr + 8 * int'(v.n));
      check(periodErr == 0, "R5", "sck period errors", periodErr, 0);
      check(csFalls == 1, "R6", "chip select falls", csFalls, 1);
      check(rxN == int'(v.n), "R7", "byte strobes", rxN, int'(v.n));
      for (int j = 0; j < int'(v.n) && j < rxN; j++)
        if (rxBuf[j] != byteAt((eLin + j) % arrSize(v.pm))) bad++;
      check(bad == 0, "R7", "bytes across boundaries", bad, 0);
      check(doneCnt == 1 && csN && !busy, "R8", "done pulse count", doneCnt, 1);
    end

    // R9: start while busy is ignored
    clearStats();
    launch(VEC[0]);
    repeat (60) @(negedge clk);
    rdMode = 2'd1; byteCount = CW'(1); pageNum = 12'd77; start = 1;
    @(negedge clk);
    start = 0;
    waitDone();
    check(mOp == 8'h03, "R9", "opcode kept", mOp, 8'h03);
    check(mAddr == {2'b00, 12'd3, 10'd17}, "R9", "address kept", mAddr, {2'b00, 12'd3, 10'd17});
    check(rxN == 4 && csFalls == 1, "R9", "count kept", rxN, 4);

    // R10: zero count is ignored
    clearStats();
    @(negedge clk);
    byteCount = '0; rdMode = 2'd0; start = 1;
    @(negedge clk);
    start = 0;
    repeat (30) @(negedge clk);
    check(!busy && csN === 1'b1, "R10", "no transfer", {busy, csN}, 2'b01);
    check(csFalls == 0 && doneCnt == 0, "R10", "no activity", csFalls + doneCnt, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule